// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Decimal Adjust

This block is the purely combinational arithmetic and logic stage of a small accumulator machine. Each cycle it takes the accumulator value, one operand byte, a three-bit operation code, a decimal-adjust request and the four condition flags left by the previous instruction. It returns the new byte, the new flags, and a write-enable for the accumulator. Decode, operand fetch, the register file and memory traffic all sit outside it.

Eight operations are selected by the code: plain and carry-in addition, plain and borrow-in subtraction, the three bitwise operations and compare. Compare computes a subtraction but does not write it back. The half-carry flag follows a distinct rule for each operation.

A separate request line overrides the operation code and applies binary-coded-decimal correction to the accumulator. It uses the subtract, half-carry and carry flags from the previous result. The correction rules after an addition are not the mirror image of those after a subtraction.

Top module: `alu8_bcd`

## Requirements
- R1: The operation code selects 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 AND, 5 XOR, 6 OR, 7 compare. For the four arithmetic codes the result is the low 8 bits of the 9-bit sum or difference, and C equals bit 8 of that value, which is the carry out or the borrow.
- R2: For add, H is set when the sum of the two low nibbles exceeds 0xF. For add-with-carry with incoming C set, one extra is added to both the nibble sum and the full sum. With C clear, add-with-carry gives exactly the add outputs.
- R3: For subtract, H is set when the accumulator low nibble is below the operand low nibble. For subtract-with-carry with incoming C set, one extra is subtracted, and H compares against the operand low nibble plus one.
- R4: N is set for subtract, subtract-with-carry and compare. It is cleared for add, add-with-carry and the three logic operations.
- R5: AND sets H and clears N and C. XOR and OR clear N, H and C.
- R6: Compare gives the same flags as subtract, with acc_we_o low. Every other operation, and every decimal adjust, drives acc_we_o high.
- R7: Z is set exactly when the 8-bit result is zero. This holds for every operation and for decimal adjust, and the incoming Z flag has no effect.
- R8: Decimal adjust with incoming N clear works in two steps. First it adds 0x06 if H is set or the low nibble exceeds 9. Then it adds 0x60, and sets C, if C is set or bits 8..4 of the partly corrected 9-bit value exceed 9. Otherwise C stays as it was.
- R9: Decimal adjust with incoming N set subtracts 0x06 only when H is set, subtracts 0x60 only when C is set, and keeps C unchanged.
- R10: Decimal adjust takes priority over the operation code, keeps N, and clears H.
- R11: flags_i and flags_o use bit 3 Z, bit 2 N, bit 1 H, bit 0 C. flag_byte_o holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4, and its bits 3..0 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand byte |
| op_i | input | 3 | Operation code (R1) |
| daa_i | input | 1 | Decimal-adjust request; overrides op_i |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| result_o | output | 8 | Computed byte (compare gives the difference) |
| flags_o | output | 4 | New flags {Z,N,H,C} |
| flag_byte_o | output | 8 | New flags packed as a status byte |
| acc_we_o | output | 1 | Accumulator write-enable |

## Verification
Immediate checks inside the top module test several properties on every input change. Z must agree with the output byte. The logic operations must leave N and C clear. Every subtracting code must raise N. Decimal adjust must always write back and clear H. Compare must never write back. The exact values of H and C, the nibble-borrow rules with carry-in, and the two sets of decimal-adjust correction rules can only be shown by the bench. It compares the outputs against its own model, using random operands under every code and incoming flag set, every accumulator byte under every flag combination for decimal adjust, and directed boundary vectors.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         half_o
);
  localparam int NB = W / 2;
  localparam int WW = W + 1;
  localparam int NW = NB + 1;

  logic [W:0]  wide;
  logic [NB:0] nib;

  always_comb begin
    if (sub_i) begin
      wide = {1'b0, a_i} - {1'b0, b_i} - WW'(cin_i);
      nib  = {1'b0, a_i[NB-1:0]} - {1'b0, b_i[NB-1:0]} - NW'(cin_i);
    end else begin
      wide = {1'b0, a_i} + {1'b0, b_i} + WW'(cin_i);
      nib  = {1'b0, a_i[NB-1:0]} + {1'b0, b_i[NB-1:0]} + NW'(cin_i);
    end
  end

  assign res_o   = wide[W-1:0];
  assign carry_o = wide[W];
  assign half_o  = nib[NB];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    res_o = a_i & b_i;
      2'd1:    res_o = a_i ^ b_i;
      2'd2:    res_o = a_i | b_i;
      default: res_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         n_i,
  input  logic         h_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  localparam int NB = W / 2;
  localparam int WW = W + 1;
  localparam logic [W:0] LO_ADJ = WW'(6);
  localparam logic [W:0] HI_ADJ = LO_ADJ << NB;

  logic [W:0] stage1;
  logic [W:0] stage2;

  always_comb begin
    c_o = c_i;
    if (!n_i) begin
      stage1 = {1'b0, a_i};
      if (h_i || (a_i[NB-1:0] > 4'd9)) stage1 = stage1 + LO_ADJ;
      stage2 = stage1;
      if (c_i || (stage1[W:NB] > 5'd9)) begin
        stage2 = stage1 + HI_ADJ;
        c_o    = 1'b1;
      end
    end else begin
      stage1 = {1'b0, a_i} - (h_i ? LO_ADJ : '0);
      stage2 = stage1 - (c_i ? HI_ADJ : '0);
    end
  end

  assign res_o = stage2[W-1:0];
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [2:0]        op_i,
  input  logic              daa_i,
  input  logic [3:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o,
  output logic [7:0]        flag_byte_o,
  output logic              acc_we_o
);
  import alu8_pkg::*;

  alu_op_e op;
  flags_t  fin;
  flags_t  fout;

  assign op  = alu_op_e'(op_i);
  assign fin = flags_t'(flags_i);

  logic              use_cin;
  logic              is_sub;
  logic [DATA_W-1:0] ar_res;
  logic              ar_carry;
  logic              ar_half;
  logic [DATA_W-1:0] lg_res;
  logic [DATA_W-1:0] dj_res;
  logic              dj_c;

  assign use_cin = fin.c && ((op == OP_ADC) || (op == OP_SBC));
  assign is_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);

  alu8_arith #(.W(DATA_W)) u_arith (
    .a_i     (acc_i),
    .b_i     (opnd_i),
    .cin_i   (use_cin),
    .sub_i   (is_sub),
    .res_o   (ar_res),
    .carry_o (ar_carry),
    .half_o  (ar_half)
  );

  alu8_logic #(.W(DATA_W)) u_logic (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sel_i (op_i[1:0]),
    .res_o (lg_res)
  );

  alu8_daa #(.W(DATA_W)) u_daa (
    .a_i   (acc_i),
    .n_i   (fin.n),
    .h_i   (fin.h),
    .c_i   (fin.c),
    .res_o (dj_res),
    .c_o   (dj_c)
  );

  always_comb begin
    result_o = ar_res;
    fout     = '0;
    acc_we_o = 1'b1;
    if (daa_i) begin
      result_o = dj_res;
      fout.n   = fin.n;
      fout.h   = 1'b0;
      fout.c   = dj_c;
    end else begin
      unique case (op)
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
          result_o = ar_res;
          fout.n   = is_sub;
          fout.h   = ar_half;
          fout.c   = ar_carry;
          acc_we_o = (op != OP_CMP);
        end
        default: begin
          result_o = lg_res;
          fout.h   = (op == OP_AND);
        end
      endcase
    end
    fout.z = (result_o == '0);
  end

  assign flags_o     = fout;
  assign flag_byte_o = {fout, 4'b0000};

  // Guards on the output select
  always_comb begin
    assert_zero_flag_R7: assert (flags_o[3] == (result_o == '0))
      else $error("Z flag disagrees with result");
    assert_logic_nc_R5: assert (daa_i || !op_i[2] || (op_i == 3'd7) ||
                                (!flags_o[2] && !flags_o[0]))
      else $error("logic op left N or C set");
    assert_sub_sets_n_R4: assert (daa_i || !is_sub || flags_o[2])
      else $error("subtracting op without N");
    assert_daa_writes_R10: assert (!daa_i || (acc_we_o && !flags_o[1]))
      else $error("decimal adjust did not write or left H");
    assert_cmp_no_write_R6: assert (daa_i || (op_i != 3'd7) || !acc_we_o)
      else $error("compare wrote accumulator");
    assert_zin_ignored_R7: assert (!(daa_i && fin.z && (result_o != '0)) || !flags_o[3])
      else $error("incoming Z leaked");
  end
endmodule

// File: tb/tb_alu8_bcd.sv
module tb_alu8_bcd;
  logic       clk;
  logic       rst_n;
  logic [7:0] acc;
  logic [7:0] opnd;
  logic [2:0] op;
  logic       daa;
  logic [3:0] fl;
  logic [7:0] res;
  logic [3:0] fo;
  logic [7:0] fbyte;
  logic       we;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  alu8_bcd dut (
    .acc_i       (acc),
    .opnd_i      (opnd),
    .op_i        (op),
    .daa_i       (daa),
    .flags_i     (fl),
    .result_o    (res),
    .flags_o     (fo),
    .flag_byte_o (fbyte),
    .acc_we_o    (we)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference model: {we, flag byte, result}
  function automatic logic [16:0] model(input int a, input int b, input int o,
                                        input bit dj, input logic [3:0] f);
    int v; bit z, n, h, c, w; int cc;
    w = 1; n = 0; h = 0; c = 0;
    if (dj) begin
      v = a; n = f[2]; c = f[0];
      if (!n) begin
        if (f[1] || ((v & 15) > 9)) v = v + 6;
        if (c || (((v >> 4) & 31) > 9)) begin v = v + 96; c = 1; end
      end else begin
        if (f[1]) v = v - 6;
        if (c) v = v - 96;
      end
      h = 0;
    end else begin
      case (o)
        0, 1: begin
          cc = (o == 1 && f[0]) ? 1 : 0;
          v = a + b + cc;
          h = ((a & 15) + (b & 15) + cc) > 15;
          c = v > 255;
        end
        2, 3, 7: begin
          cc = (o == 3 && f[0]) ? 1 : 0;
          v = a - b - cc;
          h = (a & 15) < ((b & 15) + cc);
          c = v < 0;
          n = 1;
          w = (o != 7);
        end
        4: begin v = a & b; h = 1; end
        5: v = a ^ b;
        default: v = a | b;
      endcase
    end
    v = v & 255;
    z = (v == 0);
    return {w, z, n, h, c, 4'b0000, v[7:0]};
  endfunction

  task automatic apply(input int a, input int b, input int o, input bit dj,
                       input logic [3:0] f, input string tag);
    logic [16:0] exp;
    @(negedge clk);
    acc = a[7:0]; opnd = b[7:0]; op = o[2:0]; daa = dj; fl = f;
    #1;
    exp = model(a, b, o, dj, f);
    checks++;
    if ({we, fbyte, res} !== exp || fo !== exp[15:12]) begin
      errors++;
      $display("FAIL %s a=%02h b=%02h op=%0d daa=%0b f=%04b got we=%0b fb=%02h r=%02h exp we=%0b fb=%02h r=%02h",
               tag, a[7:0], b[7:0], o, dj, f, we, fbyte, res, exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  function automatic string op_tag(input int o, input bit dj);
    if (dj) return "R8/R9/R10";
    case (o)
      0: return "R1/R2";
      1: return "R2";
      2, 3: return "R3/R4";
      7: return "R6";
      default: return "R5/R7";
    endcase
  endfunction

  initial begin
    acc = '0; opnd = '0; op = '0; daa = 1'b0; fl = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    void'($urandom(32'd7321));

    // Reset state: all-zero inputs give add of zeros, Z set, written (R11, R7)
    apply(0, 0, 0, 0, 4'b0000, "R11 reset");

    // Directed corners
    apply(8'h0F, 8'h01, 0, 0, 4'b0000, "R2 nibble carry");
    apply(8'hFF, 8'h01, 0, 0, 4'b0000, "R1 carry out zero");
    apply(8'h0E, 8'h01, 1, 0, 4'b0001, "R2 adc with C");
    apply(8'h0E, 8'h01, 1, 0, 4'b1110, "R2 adc without C");
    apply(8'h10, 8'h01, 2, 0, 4'b0000, "R3 nibble borrow");
    apply(8'h10, 8'h0F, 3, 0, 4'b0001, "R3 sbc to zero");
    apply(8'h00, 8'h01, 2, 0, 4'b0000, "R1 borrow");
    apply(8'h42, 8'h42, 7, 0, 4'b0000, "R6 compare equal");
    apply(8'h3C, 8'h0F, 4, 0, 4'b0101, "R5 and");
    apply(8'hAA, 8'hAA, 5, 0, 4'b0111, "R5 xor zero");
    apply(8'h9A, 8'h00, 0, 1, 4'b0000, "R8 adjust wrap");
    apply(8'h45, 8'h00, 7, 1, 4'b0110, "R9 adjust after sub H");
    apply(8'h00, 8'h00, 3, 1, 4'b1000, "R7 incoming Z ignored");
    apply(8'h12, 8'h00, 7, 1, 4'b0001, "R10 adjust overrides compare");

    // Exhaustive decimal adjust
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 8; f++)
        apply(a, $urandom_range(255), $urandom_range(7), 1,
              {1'($urandom_range(1)), f[2:0]}, "R8/R9/R10/R11");

    // Random operations
    for (int i = 0; i < 12000; i++) begin
      int o;
      o = $urandom_range(7);
      apply($urandom_range(255), $urandom_range(255), o, 0,
            4'($urandom_range(15)), op_tag(o, 0));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule